// File: doc/BRIEF.md
# Private down-counting timer with prescaler

This block is a 32-bit down-counter that software controls through four word registers in a 32-byte address window. A reload register, a live count register, a control register and a sticky expiry flag make up the register set. The counter moves down by one on every prescaled tick. An 8-bit divider sets how many clocks make up one tick. When the count reaches zero the expiry flag is set. A separate enable bit decides whether the flag drives the interrupt output.

Two modes are available. In single-shot mode the timer stops at zero. In auto-reload mode the count holds at zero for one full tick and only then takes the reload value again. Zero reload values and zero count writes get their own rules when the divider is zero. In those cases the timer stops instead of firing an endless run of expiries. With a non-zero divider, a zero reload value makes the timer expire once per tick.

Top module: `cdt_timer`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq` is 0.
- R2: A write to the reload register (word 0) sets both the reload value and the live count. While running, the live count (word 1) decreases by one per tick. Reads return the register value held in the cycle `rd_en` is sampled, and `rdata` is valid one clock later.
- R3: A tick occurs once every (divider + 1) clocks. The divider is control bits 15:8. The divider restarts from zero on every reload write and every count write. It also restarts on a control write that changes the enable bit (bit 0) or the mode bit (bit 1, 1 = auto-reload). The count does not change in any cycle without a tick or a write.
- R4: A tick that takes the count from 1 to 0 sets the expiry flag (word 3, bit 0). In single-shot mode the timer then stops with the count at 0.
- R5: In auto-reload mode the count stays at 0 for one tick after reaching it. The next tick loads the reload value, and that reload does not set the flag.
- R6: Writing word 3 with bit 0 set clears the flag. If a tick sets the flag in the same cycle, the set wins. Otherwise the flag stays set until it is cleared.
- R7: `irq` equals the flag ANDed with control bit 2, delayed by one clock.
- R8: If a reload write of 0 arrives while enabled with divider 0, the timer stops with count 0 and the flag does not change.
- R9: A count write of 0 while enabled in auto-reload mode with divider 0 loads the reload value instead. If that value is also 0, or the mode is single-shot, a count write of 0 with divider 0 stops the timer and leaves the flag unchanged.
- R10: Take auto-reload mode with a reload value of 0. With a non-zero divider, every tick sets the flag and the count stays 0. With divider 0, the timer stops on the tick after the expiry and raises no further flag.
- R11: A control write that turns the enable bit on in auto-reload mode while the count is 0 first copies the reload value into the count, and the timer runs.
- R12: The control register keeps only bits 0, 1, 2 and 15:8. Its other bits read as 0. Words 4 to 7 read 0. Accesses with non-zero `addr[1:0]` are ignored, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address in the 32-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the clock after `rd_en` |
| irq | output | 1 | Registered interrupt request |

## Verification
Several rules are checked on every cycle: the count holds steady between ticks and writes, a 1-to-0 tick sets the flag, single-shot mode stops at zero, and auto-reload mode holds at zero and then reloads the programmed value. The same per-cycle checks cover the flag's stickiness and write-one-to-clear, and that a zero reload write with divider 0 stops the timer without touching the flag. Other behaviour only shows over whole sequences of register accesses, so the bench scenarios must cover it. This includes the exact tick spacing for a given divider, the substitution on a zero count write, and the reload when the timer is enabled with a zero count. The scenarios also cover the repeating expiry of a zero reload value, the late stop of that case with divider 0, and the set-over-clear race.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // word index of each register (addr[4:2])
  localparam int RG_LOAD  = 0;
  localparam int RG_COUNT = 1;
  localparam int RG_CTRL  = 2;
  localparam int RG_STAT  = 3;

  // control bit positions
  localparam int CTL_EN      = 0;
  localparam int CTL_PER     = 1;
  localparam int CTL_IE      = 2;
  localparam int CTL_PRE_LSB = 8;

  // write command seen by the count core
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_COUNT = 2'd2,
    CMD_CTRL  = 2'd3
  } cmd_e;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;

  assign tick = run && !restart && (div_q >= presc);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) div_q <= '0;
    else if (div_q >= presc)    div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/cdt_core.sv
module cdt_core
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_e             cmd,
  input  logic [CNT_W-1:0] wdata,
  input  logic             en,
  input  logic             per,
  input  logic             pz,
  input  logic             n_en,
  input  logic             n_per,
  input  logic             n_pz,
  input  logic             tick,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count_q,
  output logic             run_q,
  output logic             expire,
  output logic             restart
);
  logic [CNT_W-1:0] load_d, cnt_d, cnt_eff;
  logic             run_d, mode_chg;

  assign mode_chg = (n_en != en) || (n_per != per);

  always_comb begin
    load_d  = load_q;
    cnt_d   = count_q;
    run_d   = run_q;
    expire  = 1'b0;
    restart = 1'b0;
    cnt_eff = count_q;
    if (cmd == CMD_LOAD) begin
      restart = 1'b1;
      load_d  = wdata;
      cnt_d   = wdata;
      run_d   = en && ((wdata != '0) || !pz);
    end else if (cmd == CMD_COUNT) begin
      restart = 1'b1;
      if (en && per && pz && (wdata == '0)) cnt_eff = load_q;
      else                                  cnt_eff = wdata;
      cnt_d = cnt_eff;
      run_d = en && ((cnt_eff != '0) || !pz);
    end else if ((cmd == CMD_CTRL) && mode_chg) begin
      restart = 1'b1;
      if (n_en && n_per && (count_q == '0)) cnt_eff = load_q;
      cnt_d = cnt_eff;
      run_d = n_en && ((cnt_eff != '0) || !n_pz);
    end else if (tick) begin
      if (count_q > CNT_W'(1)) begin
        cnt_d = count_q - 1'b1;
      end else if (count_q == CNT_W'(1)) begin
        cnt_d  = '0;
        expire = 1'b1;
        if (!per) run_d = 1'b0;
      end else if (!per) begin
        expire = 1'b1;
        run_d  = 1'b0;
      end else if (load_q != '0) begin
        cnt_d = load_q;
      end else if (!pz) begin
        expire = 1'b1;
      end else begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      count_q <= '0;
      run_q   <= 1'b0;
    end else begin
      load_q  <= load_d;
      count_q <= cnt_d;
      run_q   <= run_d;
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned, wr_load, wr_count, wr_ctrl, wr_stat, wr_stclr;
  logic              en_q, per_q, ie_q, status_q, pz, n_pz;
  logic [PRE_W-1:0]  presc_q;
  logic [CNT_W-1:0]  load_q, count_q, ctrl_rd;
  logic              run_q, tick, expire, restart;
  cmd_e              cmd;

  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign wr_load  = wr_en && aligned && (word == WORD_W'(RG_LOAD));
  assign wr_count = wr_en && aligned && (word == WORD_W'(RG_COUNT));
  assign wr_ctrl  = wr_en && aligned && (word == WORD_W'(RG_CTRL));
  assign wr_stat  = wr_en && aligned && (word == WORD_W'(RG_STAT));
  assign wr_stclr = wr_stat && wdata[0];
  assign pz       = (presc_q == '0);
  assign n_pz     = (wdata[CTL_PRE_LSB +: PRE_W] == '0);

  always_comb begin
    cmd = CMD_NONE;
    if (wr_load)       cmd = CMD_LOAD;
    else if (wr_count) cmd = CMD_COUNT;
    else if (wr_ctrl)  cmd = CMD_CTRL;
  end

  cdt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .cmd(cmd), .wdata(wdata),
    .en(en_q), .per(per_q), .pz(pz),
    .n_en(wdata[CTL_EN]), .n_per(wdata[CTL_PER]), .n_pz(n_pz),
    .tick(tick), .load_q(load_q), .count_q(count_q), .run_q(run_q),
    .expire(expire), .restart(restart)
  );

  cdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .restart(restart),
    .presc(presc_q), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      per_q   <= 1'b0;
      ie_q    <= 1'b0;
      presc_q <= '0;
    end else if (wr_ctrl) begin
      en_q    <= wdata[CTL_EN];
      per_q   <= wdata[CTL_PER];
      ie_q    <= wdata[CTL_IE];
      presc_q <= wdata[CTL_PRE_LSB +: PRE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           status_q <= 1'b0;
    else if (expire)   status_q <= 1'b1;
    else if (wr_stclr) status_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= status_q && ie_q;
  end

  always_comb begin
    ctrl_rd                           = '0;
    ctrl_rd[CTL_EN]                   = en_q;
    ctrl_rd[CTL_PER]                  = per_q;
    ctrl_rd[CTL_IE]                   = ie_q;
    ctrl_rd[CTL_PRE_LSB +: PRE_W]     = presc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (!aligned)                         rdata <= '0;
      else if (word == WORD_W'(RG_LOAD))    rdata <= load_q;
      else if (word == WORD_W'(RG_COUNT))   rdata <= count_q;
      else if (word == WORD_W'(RG_CTRL))    rdata <= ctrl_rd;
      else if (word == WORD_W'(RG_STAT))    rdata <= {{(CNT_W-1){1'b0}}, status_q};
      else                                  rdata <= '0;
    end
  end
endmodule

// File: rtl/cdt_chk.sv
module cdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_load,
  input logic             wr_stclr,
  input logic [CNT_W-1:0] wdata,
  input logic             tick,
  input logic             run_q,
  input logic             en_q,
  input logic             per_q,
  input logic             pz,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] load_q,
  input logic             status_q
);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !tick) |=> $stable(count_q));

  // R4
  expire_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && count_q == CNT_W'(1)) |=> (status_q && count_q == '0));

  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && !per_q && count_q == CNT_W'(1)) |=> !run_q);

  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && per_q && count_q == CNT_W'(1)) |=> (run_q && count_q == '0));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && per_q && count_q == '0 && load_q != '0) |=> (count_q == $past(load_q)));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stclr && !tick) |=> !status_q);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q && !wr_stclr) |=> status_q);

  // R8
  zero_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_load && wdata == '0 && en_q && pz) |=> (!run_q && $stable(status_q)));
endmodule

bind cdt_timer cdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_load(wr_load), .wr_stclr(wr_stclr),
  .wdata(wdata), .tick(tick), .run_q(run_q), .en_q(en_q), .per_q(per_q),
  .pz(pz), .count_q(count_q), .load_q(load_q), .status_q(status_q)
);

// File: tb/sim_cdt_timer.sv
module sim_cdt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTL = 5'h08, A_ST = 5'h0C;

  always #2 clk = ~clk;

  cdt_timer u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_LOAD, v); chk("R1", "load after reset", v, 0);
    rd(A_CNT, v);  chk("R1", "count after reset", v, 0);
    rd(A_CTL, v);  chk("R1", "ctrl after reset", v, 0);
    rd(A_ST, v);   chk("R1", "status after reset", v, 0);
    chk("R1", "irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(A_CTL, 32'hABCD_5AFC);
    rd(A_CTL, v);   chk("R12", "ctrl readback", v, 32'h0000_5A04);
    rd(5'h10, v);   chk("R12", "reserved 0x10", v, 0);
    rd(5'h1C, v);   chk("R12", "reserved 0x1C", v, 0);
    wr(5'h01, 32'h0000_0077);
    rd(A_LOAD, v);  chk("R12", "unaligned write ignored", v, 0);
    rd(5'h09, v);   chk("R12", "unaligned read", v, 0);
    wr(A_CTL, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(A_CTL, 32'h5);
    wr(A_LOAD, 5);
    rd(A_CNT, v);  chk("R2", "count after load", v, 5);
    rd(A_CNT, v);  chk("R2", "count one tick later", v, 4);
    idle(2);
    rd(A_ST, v);   chk("R4", "flag not early", v, 0);
    rd(A_CNT, v);  chk("R4", "count reached zero", v, 0);
    chk("R7", "irq raised", {31'b0, irq}, 1);
    rd(A_ST, v);   chk("R4", "flag set", v, 1);
    idle(10);
    rd(A_CNT, v);  chk("R4", "one-shot stays at zero", v, 0);
    wr(A_ST, 1);
    rd(A_ST, v);   chk("R6", "flag cleared", v, 0);
    chk("R7", "irq dropped", {31'b0, irq}, 0);
    wr(A_CTL, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(A_LOAD, 3);
    wr(A_CTL, 32'h3);
    idle(2);
    rd(A_CNT, v);  chk("R2", "periodic count", v, 1);
    rd(A_CNT, v);  chk("R5", "holds zero", v, 0);
    rd(A_CNT, v);  chk("R5", "reload after hold", v, 3);
    rd(A_ST, v);   chk("R5", "flag set on zero", v, 1);
    chk("R7", "irq masked", {31'b0, irq}, 0);
    wr(A_CTL, 0);
    wr(A_ST, 1);
  endtask

  task automatic t_presc();
    logic [31:0] v;
    wr(A_LOAD, 2);
    wr(A_CTL, 32'h0301);
    idle(3);
    rd(A_CNT, v);  chk("R3", "before first tick", v, 2);
    rd(A_CNT, v);  chk("R3", "first tick", v, 1);
    idle(2);
    rd(A_CNT, v);  chk("R3", "between ticks", v, 1);
    rd(A_CNT, v);  chk("R3", "second tick", v, 0);
    wr(A_CTL, 0);
    wr(A_ST, 1);
  endtask

  task automatic t_zero_load();
    logic [31:0] v;
    wr(A_LOAD, 2);
    wr(A_CNT, 0);
    wr(A_CTL, 32'h3);
    rd(A_CNT, v);  chk("R11", "enable reloads zero count", v, 2);
    wr(A_LOAD, 0);
    idle(10);
    rd(A_ST, v);   chk("R8", "no flag after zero load", v, 0);
    rd(A_CNT, v);  chk("R8", "stopped at zero", v, 0);
  endtask

  task automatic t_zero_count();
    logic [31:0] v;
    wr(A_ST, 1);
    wr(A_LOAD, 20);
    wr(A_CNT, 0);
    rd(A_CNT, v);  chk("R9", "zero count replaced by reload", v, 20);
    wr(A_CTL, 32'h1);
    wr(A_CNT, 0);
    idle(10);
    rd(A_ST, v);   chk("R9", "one-shot zero count no flag", v, 0);
    rd(A_CNT, v);  chk("R9", "one-shot zero count stops", v, 0);
    wr(A_CTL, 0);
    wr(A_LOAD, 0);
    wr(A_CTL, 32'h3);
    wr(A_CNT, 9);
    wr(A_CNT, 0);
    idle(10);
    rd(A_ST, v);   chk("R9", "zero reload zero count no flag", v, 0);
    rd(A_CNT, v);  chk("R9", "zero reload zero count stops", v, 0);
    wr(A_CTL, 0);
  endtask

  task automatic t_zero_reload_periodic();
    logic [31:0] v;
    wr(A_ST, 1);
    wr(A_CTL, 32'h0103);
    idle(1);
    wr(A_ST, 1);
    rd(A_ST, v);   chk("R6", "set wins over clear", v, 1);
    idle(1);
    wr(A_ST, 1);
    rd(A_ST, v);   chk("R6", "clear off tick", v, 0);
    rd(A_ST, v);   chk("R10", "flag again next period", v, 1);
    rd(A_CNT, v);  chk("R10", "count stays zero", v, 0);
    wr(A_CTL, 0);
    wr(A_ST, 1);
    wr(A_CTL, 32'h3);
    wr(A_CNT, 3);
    idle(5);
    rd(A_ST, v);   chk("R10", "expiry with divider 0", v, 1);
    rd(A_CNT, v);  chk("R10", "count zero", v, 0);
    wr(A_ST, 1);
    idle(10);
    rd(A_ST, v);   chk("R10", "stopped, no repeat", v, 0);
    rd(A_CNT, v);  chk("R10", "stays zero", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_oneshot();
    t_periodic();
    t_presc();
    t_zero_load();
    t_zero_count();
    t_zero_reload_periodic();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule